// File: doc/BRIEF.md
# Dual-Output PWM Generator with Selectable Time Base

This block produces a high-side and a low-side pulse-width-modulated signal from one generator. The signals are raw: override, fault and dead-time stages are expected downstream. A primary counter creates the high-side waveform. The primary counter's period comes from one of two places: a master period shared across the chip, or the generator's own phase/period value. A second counter supports a fully independent low side. When the generator's own time base is selected, that counter can run from a separate secondary period.

There are two counting shapes. In edge-aligned counting the counter ramps up and wraps to zero. In center-aligned counting it ramps up and then back down, which gives pulses that are symmetric about the peak. Center-aligned counting takes effect only when the generator's own time base is selected. A 2-bit output mode sets how the low side relates to the high side: inverse, copy, alternating periods, or independent. A clock enable paces the counters. A module enable starts them from zero and forces both outputs low while it is off.

Top module: `pwm_dual_gen`

## Requirements
- R1: In edge-aligned counting a counter takes the values 0,1,…,P and then returns to 0 on the next counted step, so one period lasts P+1 counted steps (P = active period; P = 0 holds the count at 0).
- R2: An output's compare is asserted in every cycle in which its counter value is less than or equal to its active duty value; a duty of P or more keeps it asserted for the whole period.
- R3: With `itb_sel` = 0 the primary period is `master_per`; with `itb_sel` = 1 it is `phase_per`, and `master_per` has no effect.
- R4: With `cam_req` = 1 and `itb_sel` = 1 the counter runs 0,1,…,P,P-1,…,1 and then starts again at 0 (2P steps per period), and the compare of R2 applies on both ramps.
- R5: With `itb_sel` = 0, `cam_req` has no effect and counting stays edge-aligned.
- R6: `out_mode` codes: 00 gives `pwm_lo` = NOT `pwm_hi`; 01 gives `pwm_lo` = `pwm_hi`; 10 (push-pull) applies the primary compare to `pwm_hi` in the 1st, 3rd, … periods after enable and to `pwm_lo` in the 2nd, 4th, … periods, never both at once; 11 (independent) gives `pwm_hi` from `duty_hi` and `pwm_lo` from `duty_lo`.
- R7: In mode 11 with `itb_sel` = 1 the low side has its own counter with period `sec_per`; in mode 11 with `itb_sel` = 0 the low side compares `duty_lo` against a counter that shares the primary period, and `sec_per` has no effect. In modes 00 to 10, `duty_lo` has no effect.
- R8: Period and duty inputs are copied into the active values only when a counter wraps back to its start, or while the module is disabled; a change in the middle of a period takes effect from the next period.
- R9: While `mod_en` = 0 both outputs are low in the same cycle and all counters are held at 0; after enable the first cycle shows count 0.
- R10: While `clk_en` = 0 the counters and outputs hold their values.
- R11: After reset, with `mod_en` low, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Count step enable |
| mod_en | input | 1 | Generator enable; low clears counters and outputs |
| out_mode | input | 2 | Output mode: 00 complementary, 01 redundant, 10 push-pull, 11 independent |
| itb_sel | input | 1 | 1 selects the generator's own period instead of the master period |
| cam_req | input | 1 | Center-aligned counting request (honoured only with itb_sel = 1) |
| master_per | input | W | Shared master period |
| phase_per | input | W | Generator's own primary period |
| sec_per | input | W | Secondary period for the independent low side |
| duty_hi | input | W | Primary duty value |
| duty_lo | input | W | Low-side duty value in independent mode |
| pwm_hi | output | 1 | Raw high-side PWM |
| pwm_lo | output | 1 | Raw low-side PWM |

## Verification
On every cycle, the assertions check these rules: the wrap to zero at the top of an edge-aligned ramp, the turn-around at the center-aligned peak, the freeze while the clock enable is low, the rule that active values stay fixed between wraps, zeroed counters and low outputs while disabled, and the output relations for complementary, redundant and push-pull modes. Only the bench's scenarios can show the pulse counts over whole periods. These counts show the choice of period source, the doubled center-aligned period, the separate secondary period, and the alternation of push-pull periods. The directed scenarios also show that a mid-period register change has no visible effect until the next wrap, and that a stalled clock enable holds a pulse that would otherwise have ended.

// File: rtl/pwm_dual_pkg.sv
package pwm_dual_pkg;

  typedef enum logic [1:0] {
    OM_COMP     = 2'b00,
    OM_REDUN    = 2'b01,
    OM_PUSHPULL = 2'b10,
    OM_INDEP    = 2'b11
  } out_mode_e;

  // Maps the two compare results onto the pins: returns {hi, lo}.
  function automatic logic [1:0] route_pins(input out_mode_e m, input logic cmp_a,
                                            input logic cmp_b, input logic alt);
    logic [1:0] r;
    unique case (m)
      OM_COMP:     r = {cmp_a, ~cmp_a};
      OM_REDUN:    r = {cmp_a, cmp_a};
      OM_PUSHPULL: r = {cmp_a & ~alt, cmp_a & alt};
      default:     r = {cmp_a, cmp_b};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pwm_tbase.sv
module pwm_tbase #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         step,
  input  logic         center,
  input  logic [W-1:0] per_in,
  input  logic [W-1:0] duty_in,
  output logic         on_o,
  output logic         wrap_o
);

  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] cnt_q, per_act_q, duty_act_q;
  logic         up_q;

  // Next-state arithmetic: returns {wrap, up_next, count_next}.
  function automatic logic [W+1:0] advance(input logic [W-1:0] c, input logic up,
                                           input logic [W-1:0] p, input logic ctr);
    if (!ctr) begin
      if (c >= p) return {1'b1, 1'b1, ZERO};
      return {1'b0, 1'b1, c + ONE};
    end
    if (up) begin
      if (c >= p) begin
        if (c <= ONE) return {1'b1, 1'b1, ZERO};
        return {1'b0, 1'b0, c - ONE};
      end
      return {1'b0, 1'b1, c + ONE};
    end
    if (c <= ONE) return {1'b1, 1'b1, ZERO};
    return {1'b0, 1'b0, c - ONE};
  endfunction

  logic [W+1:0] nxt;
  logic         adv_wrap;

  always_comb begin
    nxt      = advance(cnt_q, up_q, per_act_q, center);
    adv_wrap = nxt[W+1];
  end

  assign wrap_o = run & step & adv_wrap;
  assign on_o   = run & (cnt_q <= duty_act_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      up_q       <= 1'b1;
      per_act_q  <= '0;
      duty_act_q <= '0;
    end else begin
      if (!run) begin
        cnt_q <= '0;
        up_q  <= 1'b1;
      end else if (step) begin
        cnt_q <= nxt[W-1:0];
        up_q  <= nxt[W];
      end
      if (!run || wrap_o) begin
        per_act_q  <= per_in;
        duty_act_q <= duty_in;
      end
    end
  end

  // R1: top of an edge-aligned ramp returns to zero
  p_edge_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    run && step && !center && (cnt_q >= per_act_q) |=> cnt_q == '0);

  // R4: the center-aligned peak turns the count downward
  p_center_turn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run && step && center && up_q && (cnt_q >= per_act_q) && (cnt_q > ONE)
    |=> !up_q && (cnt_q == $past(cnt_q) - ONE));

  // R10: no step, no movement
  p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    run && !step |=> $stable(cnt_q) && $stable(up_q));

  // R9: disabled counter sits at zero
  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0);

  // R8: active copies only change at a wrap or while disabled
  p_shadow_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    run && !wrap_o |=> $stable(per_act_q) && $stable(duty_act_q));

endmodule

// File: rtl/pwm_outsel.sv
module pwm_outsel
  import pwm_dual_pkg::*;
(
  input  out_mode_e mode,
  input  logic      run,
  input  logic      cmp_a,
  input  logic      cmp_b,
  input  logic      alt,
  output logic      hi,
  output logic      lo
);

  logic [1:0] pins;

  always_comb begin
    pins = route_pins(mode, cmp_a, cmp_b, alt);
    hi   = run & pins[1];
    lo   = run & pins[0];
  end

endmodule

// File: rtl/pwm_dual_gen.sv
module pwm_dual_gen
  import pwm_dual_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clk_en,
  input  logic         mod_en,
  input  logic [1:0]   out_mode,
  input  logic         itb_sel,
  input  logic         cam_req,
  input  logic [W-1:0] master_per,
  input  logic [W-1:0] phase_per,
  input  logic [W-1:0] sec_per,
  input  logic [W-1:0] duty_hi,
  input  logic [W-1:0] duty_lo,
  output logic         pwm_hi,
  output logic         pwm_lo
);

  out_mode_e    mode;
  logic         center_en, split_tb;
  logic [W-1:0] pri_per, lo_per;
  logic         pri_on, pri_wrap, sec_on, sec_wrap;
  logic         pp_alt_q;

  assign mode      = out_mode_e'(out_mode);
  assign center_en = cam_req & itb_sel;
  assign split_tb  = itb_sel & (mode == OM_INDEP);
  assign pri_per   = itb_sel ? phase_per : master_per;
  assign lo_per    = split_tb ? sec_per : pri_per;

  pwm_tbase #(.W(W)) u_pri (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (mod_en),
    .step    (clk_en),
    .center  (center_en),
    .per_in  (pri_per),
    .duty_in (duty_hi),
    .on_o    (pri_on),
    .wrap_o  (pri_wrap)
  );

  pwm_tbase #(.W(W)) u_sec (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (mod_en),
    .step    (clk_en),
    .center  (center_en),
    .per_in  (lo_per),
    .duty_in (duty_lo),
    .on_o    (sec_on),
    .wrap_o  (sec_wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pp_alt_q <= 1'b0;
    else if (!mod_en)  pp_alt_q <= 1'b0;
    else if (pri_wrap) pp_alt_q <= ~pp_alt_q;
  end

  pwm_outsel u_out (
    .mode  (mode),
    .run   (mod_en),
    .cmp_a (pri_on),
    .cmp_b (sec_on),
    .alt   (pp_alt_q),
    .hi    (pwm_hi),
    .lo    (pwm_lo)
  );

  // R9: disabled generator drives both pins low
  p_off_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |-> !pwm_hi && !pwm_lo);

  // R9: no wrap events from a stopped secondary counter
  p_sec_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |-> !sec_wrap && !pri_wrap);

  // R6: complementary pins are always opposite
  p_comp_inv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mod_en && (out_mode == 2'b00) |-> pwm_lo != pwm_hi);

  // R6: redundant pins always agree
  p_redun_eq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mod_en && (out_mode == 2'b01) |-> pwm_lo == pwm_hi);

  // R6: push-pull never drives both pins
  p_pp_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode == 2'b10) |-> !(pwm_hi && pwm_lo));

endmodule

// File: tb/sim_pwm_dual_gen.sv
module sim_pwm_dual_gen;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         clk_en = 1'b1;
  logic         mod_en = 1'b0;
  logic [1:0]   out_mode = 2'b00;
  logic         itb_sel = 1'b0;
  logic         cam_req = 1'b0;
  logic [W-1:0] master_per = '0;
  logic [W-1:0] phase_per = '0;
  logic [W-1:0] sec_per = '0;
  logic [W-1:0] duty_hi = '0;
  logic [W-1:0] duty_lo = '0;
  logic         pwm_hi, pwm_lo;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  pwm_dual_gen #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .mod_en(mod_en),
    .out_mode(out_mode), .itb_sel(itb_sel), .cam_req(cam_req),
    .master_per(master_per), .phase_per(phase_per), .sec_per(sec_per),
    .duty_hi(duty_hi), .duty_lo(duty_lo), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic        itb;
    logic        cam;
    logic [15:0] mper;
    logic [15:0] pper;
    logic [15:0] sper;
    logic [15:0] dh;
    logic [15:0] dl;
    logic [7:0]  len;
    logic [7:0]  ehi;
    logic [7:0]  elo;
    logic [7:0]  req;
  } vec_t;

  // Expected counts: edge period P+1 with min(D,P)+1 high; center 2P with 2D+1 high.
  localparam vec_t VECS [11] = '{
    '{2'b00, 1'b0, 1'b0, 16'd9, 16'd0, 16'd0, 16'd3, 16'd0, 8'd20, 8'd8,  8'd12, 8'd1},  // R1 R2 complementary
    '{2'b01, 1'b0, 1'b0, 16'd7, 16'd0, 16'd0, 16'd2, 16'd0, 8'd16, 8'd6,  8'd6,  8'd6},  // R6 redundant
    '{2'b00, 1'b1, 1'b0, 16'd9, 16'd4, 16'd0, 16'd1, 16'd0, 8'd10, 8'd4,  8'd6,  8'd3},  // R3 own period
    '{2'b00, 1'b1, 1'b1, 16'd0, 16'd5, 16'd0, 16'd2, 16'd0, 8'd20, 8'd10, 8'd10, 8'd4},  // R4 center
    '{2'b00, 1'b0, 1'b1, 16'd5, 16'd9, 16'd0, 16'd2, 16'd0, 8'd18, 8'd9,  8'd9,  8'd5},  // R5 cam ignored
    '{2'b11, 1'b1, 1'b0, 16'd0, 16'd3, 16'd5, 16'd1, 16'd4, 8'd24, 8'd12, 8'd20, 8'd7},  // R7 split periods
    '{2'b11, 1'b0, 1'b0, 16'd7, 16'd0, 16'd3, 16'd0, 16'd5, 8'd16, 8'd2,  8'd12, 8'd7},  // R7 shared period
    '{2'b10, 1'b0, 1'b0, 16'd4, 16'd0, 16'd0, 16'd2, 16'd0, 8'd20, 8'd6,  8'd6,  8'd6},  // R6 push-pull
    '{2'b01, 1'b0, 1'b0, 16'd3, 16'd0, 16'd0, 16'd7, 16'd0, 8'd8,  8'd8,  8'd8,  8'd2},  // R2 duty over period
    '{2'b11, 1'b1, 1'b1, 16'd0, 16'd3, 16'd2, 16'd1, 16'd0, 8'd12, 8'd6,  8'd3,  8'd4},  // R4 center both sides
    '{2'b00, 1'b0, 1'b0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 8'd5,  8'd5,  8'd0,  8'd1}   // R1 zero period
  };

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic restart(input logic [1:0] m, input logic itb, input logic cam,
                         input int mp, input int pp, input int sp, input int dh, input int dl);
    @(negedge clk);
    mod_en = 1'b0; clk_en = 1'b1;
    out_mode = m; itb_sel = itb; cam_req = cam;
    master_per = W'(mp); phase_per = W'(pp); sec_per = W'(sp);
    duty_hi = W'(dh); duty_lo = W'(dl);
    @(negedge clk);
    mod_en = 1'b1;
    #0.5;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=<20000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    // R11: reset state
    #1;
    check("R11 hi in reset", int'(pwm_hi), 0);
    check("R11 lo in reset", int'(pwm_lo), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 hi after reset", int'(pwm_hi), 0);
    check("R11 lo after reset", int'(pwm_lo), 0);

    // Vector table walk
    for (int v = 0; v < 11; v++) begin
      int nh, nl;
      nh = 0; nl = 0;
      restart(VECS[v].mode, VECS[v].itb, VECS[v].cam, int'(VECS[v].mper), int'(VECS[v].pper),
              int'(VECS[v].sper), int'(VECS[v].dh), int'(VECS[v].dl));
      for (int i = 0; i < int'(VECS[v].len); i++) begin
        nh += int'(pwm_hi);
        nl += int'(pwm_lo);
        @(negedge clk);
        #0.5;
      end
      check($sformatf("R%0d vec%0d hi count", VECS[v].req, v), nh, int'(VECS[v].ehi));
      check($sformatf("R%0d vec%0d lo count", VECS[v].req, v), nl, int'(VECS[v].elo));
    end

    // R8: mid-period change waits for the wrap
    begin
      int lows, highs;
      lows = 0; highs = 0;
      restart(2'b01, 1'b0, 1'b0, 9, 0, 0, 3, 0);
      for (int i = 0; i < 20; i++) begin
        if (i >= 4 && i <= 9 && !pwm_hi) lows++;
        if (i >= 10 && pwm_hi) highs++;
        if (i == 2) begin
          master_per = W'(4);
          duty_hi = W'(8);
        end
        @(negedge clk);
        #0.5;
      end
      check("R8 old duty kept until wrap", lows, 6);
      check("R8 new period and duty after wrap", highs, 10);
    end

    // R10: stalled step holds a pulse that would otherwise end
    begin
      int held;
      held = 0;
      restart(2'b01, 1'b0, 1'b0, 9, 0, 0, 3, 0);
      repeat (2) begin @(negedge clk); #0.5; end
      clk_en = 1'b0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        #0.5;
        held += int'(pwm_hi);
      end
      check("R10 hold while stalled", held, 6);
      clk_en = 1'b1;
      @(negedge clk); #0.5;
      check("R10 resume count 3", int'(pwm_hi), 1);
      @(negedge clk); #0.5;
      check("R10 resume count 4", int'(pwm_hi), 0);
    end

    // R9: disable forces both pins low at once and restarts from zero
    restart(2'b00, 1'b0, 1'b0, 9, 0, 0, 3, 0);
    repeat (5) begin @(negedge clk); #0.5; end
    check("R9 lo before disable", int'(pwm_lo), 1);
    mod_en = 1'b0;
    #0.5;
    check("R9 hi while disabled", int'(pwm_hi), 0);
    check("R9 lo while disabled", int'(pwm_lo), 0);
    @(negedge clk);
    mod_en = 1'b1;
    #0.5;
    check("R9 count zero after enable", int'(pwm_hi), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule